// File: doc/BRIEF.md
# Receive Error Event Status Counters

This block sits behind a T1 receive path and turns error strobes into small status fields for a host status word. The strobes are framing-bit pattern errors, bipolar violations, CRC-6 errors and controlled slips, and each lasts one clock cycle. A free-running 1 ms tick sets the time base. A mode flag marks extended superframe operation. The detection of the errors and the serialising of the status word are done elsewhere.

Most fields are toggle bits, so the host finds new activity by comparing two reads. The framing-error bit toggles once per four framing errors, and it is rate-limited. A three-state machine guards it:
- `FE_READY`: no hold-off is active. A completed group of four errors toggles the bit at once, starts the hold-off (*fire*) and moves to `FE_HOLD`.
- `FE_HOLD`: the hold-off is running and nothing is waiting. A completed group moves to `FE_PEND` (*defer*). If the hold-off ends with no group in the same cycle, the machine returns to `FE_READY` (*release*). If a group completes in that same cycle, the bit toggles, the hold-off restarts and the machine stays in `FE_HOLD` (*refire*).
- `FE_PEND`: a toggle is waiting. When the hold-off ends, the bit toggles, the hold-off restarts and the machine goes to `FE_HOLD` (*apply*). Further groups in this state merge into the single pending toggle.

The violation fields are the three top bits of a free-running 9-bit violation counter. The CRC field is a 3-bit wrapping counter that runs only in extended superframe mode.

Top module: `fes_event_status`

## Requirements
- R1: With no hold-off active, the framing status bit `fe_status` toggles in the cycle after every fourth framing error.
- R2: After `fe_status` toggles, it does not change again until 96 `ms_tick` pulses have been seen.
- R3: Framing error groups that complete during a hold-off produce exactly one deferred toggle. That toggle is applied on the 96th tick after the previous toggle, and a new hold-off starts from it.
- R4: `bpv_status` toggles once per 256 bipolar violations. It is bit 8 of the violation count.
- R5: `bpv_sub[1]` toggles every 128 violations and `bpv_sub[0]` toggles every 64 violations. These are bits 7 and 6 of the count.
- R6: In extended superframe mode (`esf_mode`=1), `crc_count` increments on each CRC error and goes from 7 back to 0.
- R7: While `esf_mode` is 0, `crc_count` is 0 from the next cycle on, and CRC error strobes have no effect.
- R8: `slip_status` toggles on every slip strobe.
- R9: Reset clears all counts, all toggle bits and the hold-off. After reset, four framing errors toggle `fe_status` at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| esf_mode | input | 1 | Extended superframe mode enable |
| fe_err_evt | input | 1 | Framing-bit error strobe |
| bpv_evt | input | 1 | Bipolar violation strobe |
| crc_err_evt | input | 1 | CRC-6 error strobe |
| slip_evt | input | 1 | Controlled slip strobe |
| fe_status | output | 1 | Rate-limited framing error toggle bit |
| bpv_status | output | 1 | Toggle bit, one change per 256 violations |
| bpv_sub | output | 2 | Toggle bits, one change per 128 and per 64 violations |
| crc_count | output | 3 | Wrapping CRC error count |
| slip_status | output | 1 | Slip toggle bit |

## Verification
The assertions assume every event input is a one-cycle strobe sampled at the clock, with at most one event per input per cycle. They assume that `ms_tick` is a single-cycle pulse.

The hold-off check counts ticks from each toggle, so it assumes the tick source does not stall.

The stimulus drives each strobe for exactly one cycle from the falling edge. It never places a framing error in the same cycle as a tick, so the refire path is not used. It changes `esf_mode` only between CRC strobes.

// File: rtl/fes_pkg.sv
package fes_pkg;
    typedef enum logic [1:0] {
        FE_READY = 2'd0,
        FE_HOLD  = 2'd1,
        FE_PEND  = 2'd2
    } fe_state_e;

    localparam int FE_GROUP_DEF   = 4;
    localparam int HOLD_TICKS_DEF = 96;
    localparam int BPV_WIDTH_DEF  = 9;
    localparam int CRC_WIDTH_DEF  = 3;
endpackage

// File: rtl/fes_frame_err.sv
module fes_frame_err #(
    parameter int GROUP      = fes_pkg::FE_GROUP_DEF,
    parameter int HOLD_TICKS = fes_pkg::HOLD_TICKS_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ms_tick,
    input  logic err_evt,
    output logic fe_bit
);
    import fes_pkg::*;

    localparam int CW = (GROUP > 1) ? $clog2(GROUP) : 1;
    localparam int TW = $clog2(HOLD_TICKS + 1);

    fe_state_e      state_q, state_d;
    logic [CW-1:0]  grp_q;
    logic [TW-1:0]  tmr_q;
    logic           fe_q;
    logic           group_done, hold_end, fire;

    assign group_done = err_evt && (grp_q == CW'(GROUP - 1));
    assign hold_end   = ms_tick && (tmr_q == TW'(HOLD_TICKS - 1));

    // next state and toggle request
    always_comb begin
        state_d = state_q;
        fire    = 1'b0;
        unique case (state_q)
            FE_READY: begin
                if (group_done) begin
                    fire    = 1'b1;            // fire
                    state_d = FE_HOLD;
                end
            end
            FE_HOLD: begin
                if (hold_end && group_done) begin
                    fire    = 1'b1;            // refire
                    state_d = FE_HOLD;
                end else if (hold_end) begin
                    state_d = FE_READY;        // release
                end else if (group_done) begin
                    state_d = FE_PEND;         // defer
                end
            end
            FE_PEND: begin
                if (hold_end) begin
                    fire    = 1'b1;            // apply
                    state_d = FE_HOLD;
                end
            end
            default: state_d = FE_READY;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FE_READY;
        else        state_q <= state_d;
    end

    // outputs, group counter and hold-off timer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grp_q <= '0;
            tmr_q <= '0;
            fe_q  <= 1'b0;
        end else begin
            if (err_evt)
                grp_q <= group_done ? '0 : grp_q + 1'b1;
            if (fire) begin
                fe_q  <= ~fe_q;
                tmr_q <= '0;
            end else if (ms_tick && state_q != FE_READY) begin
                tmr_q <= tmr_q + 1'b1;
            end
        end
    end

    assign fe_bit = fe_q;

    // assertion support: ticks seen since the last toggle
    logic [TW-1:0] seen_q;
    logic          armed_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q  <= '0;
            armed_q <= 1'b0;
        end else if (fe_q != fe_bit_prev) begin
            seen_q  <= '0;
            armed_q <= 1'b1;
        end else if (ms_tick && seen_q < TW'(HOLD_TICKS)) begin
            seen_q  <= seen_q + 1'b1;
        end
    end

    logic fe_bit_prev;
    always_ff @(posedge clk) begin
        if (!rst_n) fe_bit_prev <= 1'b0;
        else        fe_bit_prev <= fe_q;
    end

    assert_fe_holdoff_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && fe_q != fe_bit_prev) |->
            (int'($past(seen_q)) + int'($past(ms_tick)) >= HOLD_TICKS));

    assert_fe_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fe_q) |-> ($past(err_evt) || $past(state_q) == FE_PEND));

    assert_fe_pend_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FE_PEND && !ms_tick) |=> (state_q == FE_PEND && $stable(fe_q)));
endmodule

// File: rtl/fes_bpv_count.sv
module fes_bpv_count #(
    parameter int WIDTH = fes_pkg::BPV_WIDTH_DEF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       evt,
    output logic [2:0] top_bits
);
    logic [WIDTH-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)   cnt_q <= '0;
        else if (evt) cnt_q <= cnt_q + 1'b1;
    end

    assign top_bits = cnt_q[WIDTH-1 -: 3];

    assert_bpv_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cnt_q[WIDTH-1]) |-> ($past(evt) && $past(&cnt_q[WIDTH-2:0])));

    assert_bpv_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !evt |=> $stable(top_bits));
endmodule

// File: rtl/fes_crc_count.sv
module fes_crc_count #(
    parameter int WIDTH = fes_pkg::CRC_WIDTH_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             esf_mode,
    input  logic             evt,
    output logic [WIDTH-1:0] count
);
    logic [WIDTH-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !esf_mode) cnt_q <= '0;
        else if (evt)            cnt_q <= cnt_q + 1'b1;
    end

    assign count = cnt_q;

    assert_crc_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !esf_mode |=> (count == '0));

    assert_crc_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (esf_mode && evt && &count) |=> (count == '0));
endmodule

// File: rtl/fes_event_status.sv
module fes_event_status #(
    parameter int FE_GROUP   = fes_pkg::FE_GROUP_DEF,
    parameter int HOLD_TICKS = fes_pkg::HOLD_TICKS_DEF,
    parameter int BPV_WIDTH  = fes_pkg::BPV_WIDTH_DEF,
    parameter int CRC_WIDTH  = fes_pkg::CRC_WIDTH_DEF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ms_tick,
    input  logic                 esf_mode,
    input  logic                 fe_err_evt,
    input  logic                 bpv_evt,
    input  logic                 crc_err_evt,
    input  logic                 slip_evt,
    output logic                 fe_status,
    output logic                 bpv_status,
    output logic [1:0]           bpv_sub,
    output logic [CRC_WIDTH-1:0] crc_count,
    output logic                 slip_status
);
    logic [2:0] bpv_top;
    logic       slip_q;

    fes_frame_err #(.GROUP(FE_GROUP), .HOLD_TICKS(HOLD_TICKS)) u_fe (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick),
        .err_evt(fe_err_evt), .fe_bit(fe_status)
    );

    fes_bpv_count #(.WIDTH(BPV_WIDTH)) u_bpv (
        .clk(clk), .rst_n(rst_n), .evt(bpv_evt), .top_bits(bpv_top)
    );

    fes_crc_count #(.WIDTH(CRC_WIDTH)) u_crc (
        .clk(clk), .rst_n(rst_n), .esf_mode(esf_mode),
        .evt(crc_err_evt), .count(crc_count)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)        slip_q <= 1'b0;
        else if (slip_evt) slip_q <= ~slip_q;
    end

    assign bpv_status  = bpv_top[2];
    assign bpv_sub     = bpv_top[1:0];
    assign slip_status = slip_q;

    assert_slip_toggle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        slip_evt |=> (slip_status != $past(slip_status)));

    assert_slip_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !slip_evt |=> $stable(slip_status));
endmodule

// File: tb/fes_event_status_bench.sv
module fes_event_status_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ms_tick = 1'b0, esf_mode = 1'b0;
    logic       fe_err_evt = 1'b0, bpv_evt = 1'b0, crc_err_evt = 1'b0, slip_evt = 1'b0;
    logic       fe_status, bpv_status, slip_status;
    logic [1:0] bpv_sub;
    logic [2:0] crc_count;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    fes_event_status u_fes_event_status (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .esf_mode(esf_mode),
        .fe_err_evt(fe_err_evt), .bpv_evt(bpv_evt), .crc_err_evt(crc_err_evt),
        .slip_evt(slip_evt), .fe_status(fe_status), .bpv_status(bpv_status),
        .bpv_sub(bpv_sub), .crc_count(crc_count), .slip_status(slip_status)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic fe_pulse(input int n);
        for (int i = 0; i < n; i++) begin
            fe_err_evt = 1'b1; @(negedge clk); fe_err_evt = 1'b0; @(negedge clk);
        end
    endtask
    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            ms_tick = 1'b1; @(negedge clk); ms_tick = 1'b0; @(negedge clk);
        end
    endtask
    task automatic bpv_pulse(input int n);
        for (int i = 0; i < n; i++) begin
            bpv_evt = 1'b1; @(negedge clk); bpv_evt = 1'b0;
        end
    endtask
    task automatic crc_pulse(input int n);
        for (int i = 0; i < n; i++) begin
            crc_err_evt = 1'b1; @(negedge clk); crc_err_evt = 1'b0;
        end
    endtask
    task automatic do_reset;
        rst_n = 1'b0; @(negedge clk); @(negedge clk); rst_n = 1'b1; @(negedge clk);
    endtask

    task automatic test_reset_state;
        chk("R9 fe_status", int'(fe_status), 0);
        chk("R9 bpv_status", int'(bpv_status), 0);
        chk("R9 bpv_sub", int'(bpv_sub), 0);
        chk("R9 crc_count", int'(crc_count), 0);
        chk("R9 slip_status", int'(slip_status), 0);
    endtask

    task automatic test_framing;
        fe_pulse(3);
        chk("R1 three errors", int'(fe_status), 0);
        fe_pulse(1);
        chk("R1 fourth error", int'(fe_status), 1);
        tick(50);
        fe_pulse(8);
        chk("R2 held during hold-off", int'(fe_status), 1);
        tick(45);
        chk("R2 still held at 95 ticks", int'(fe_status), 1);
        tick(1);
        chk("R3 pending applied at tick 96", int'(fe_status), 0);
        tick(95);
        chk("R3 single pending toggle", int'(fe_status), 0);
        tick(1);
        fe_pulse(4);
        chk("R1 after hold-off ends", int'(fe_status), 1);
    endtask

    task automatic test_bpv;
        bpv_pulse(63);
        chk("R5 sub at 63", int'(bpv_sub), 0);
        bpv_pulse(1);
        chk("R5 sub at 64", int'(bpv_sub), 1);
        bpv_pulse(64);
        chk("R5 sub at 128", int'(bpv_sub), 2);
        bpv_pulse(64);
        chk("R5 sub at 192", int'(bpv_sub), 3);
        chk("R4 status at 192", int'(bpv_status), 0);
        bpv_pulse(64);
        chk("R4 status at 256", int'(bpv_status), 1);
        chk("R5 sub at 256", int'(bpv_sub), 0);
        bpv_pulse(256);
        chk("R4 status at 512", int'(bpv_status), 0);
    endtask

    task automatic test_crc;
        esf_mode = 1'b1; @(negedge clk);
        crc_pulse(7);
        chk("R6 count seven", int'(crc_count), 7);
        crc_pulse(1);
        chk("R6 wrap to zero", int'(crc_count), 0);
        crc_pulse(3);
        chk("R6 count three", int'(crc_count), 3);
        esf_mode = 1'b0; @(negedge clk);
        chk("R7 cleared outside ESF", int'(crc_count), 0);
        crc_pulse(5);
        chk("R7 strobes ignored", int'(crc_count), 0);
        esf_mode = 1'b1; @(negedge clk);
        crc_pulse(1);
        chk("R6 restart from zero", int'(crc_count), 1);
    endtask

    task automatic test_slip;
        slip_evt = 1'b1; @(negedge clk); slip_evt = 1'b0;
        chk("R8 first slip", int'(slip_status), 1);
        slip_evt = 1'b1; @(negedge clk); slip_evt = 1'b0;
        chk("R8 second slip", int'(slip_status), 0);
        @(negedge clk); @(negedge clk);
        chk("R8 no slip no change", int'(slip_status), 0);
        slip_evt = 1'b1; @(negedge clk); slip_evt = 1'b0;
        chk("R8 third slip", int'(slip_status), 1);
    endtask

    task automatic test_reset_clears_holdoff;
        // fe_status is 1 with a fresh hold-off running
        do_reset;
        test_reset_state;
        fe_pulse(4);
        chk("R9 hold-off cleared by reset", int'(fe_status), 1);
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        @(negedge clk);
        do_reset;
        test_reset_state;
        test_framing;
        test_bpv;
        test_crc;
        test_slip;
        test_reset_clears_holdoff;
        done = 1'b1;
        finish_run;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
            finish_run;
        end
    end
endmodule